// File: doc/BRIEF.md
# Page Write Protection Checker

This block decides, one request at a time, whether a write into a 16-bit-word memory space may go ahead. It keeps a bank of protection registers. Each bit in the bank covers one fixed page of 256 consecutive words. When a write request arrives, the block looks up the bit for the target page and answers one clock later with either a grant pulse or a violation pulse. Reads never pass through this block.

A privileged requester is always granted. An unprivileged write to a page whose bit is set is refused. The protection bank is loaded through a separate update port. An update is accepted only when it carries the privileged flag. An unprivileged update is dropped and produces its own one-cycle illegal-update pulse. A combinational readback port returns any register of the bank. Reset clears every bit, so after reset every page is writable.

Top module: `wprot_guard`

## Requirements
- R1: After reset every protection register reads back as 0, and an unprivileged write to any address is granted.
- R2: An update with `cfg_we_i=1` and `cfg_priv_i=1` loads `cfg_data_i` into register `cfg_idx_i`. Readback shows the new value from the clock edge that samples the update onward.
- R3: An update with `cfg_we_i=1` and `cfg_priv_i=0` leaves every register unchanged. It raises `bad_cfg_o` for exactly the cycle after it is sampled, and `bad_cfg_o` is low otherwise.
- R4: `grant_o` or `viol_o` is high for exactly one cycle, the cycle after a request with `req_valid_i=1` is sampled. Both are low after a cycle with no valid request, and they are never high together.
- R5: An unprivileged write (`req_priv_i=0`) to a page whose protection bit is 1 produces `viol_o`.
- R6: An unprivileged write to a page whose protection bit is 0 produces `grant_o`.
- R7: A privileged write (`req_priv_i=1`) is granted whatever its protection bit holds.
- R8: The protection bit for an address is bit `addr[11:8]` of register `addr[15:12]`. Address bits [7:0] have no effect on the decision.
- R9: A request sampled in the same cycle as a privileged update to its register is judged on the register value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Protection register update strobe |
| cfg_priv_i | input | 1 | Privileged flag for the update |
| cfg_idx_i | input | 4 | Register index of the update |
| cfg_data_i | input | 16 | New register value |
| rd_idx_i | input | 4 | Readback register index |
| rd_data_o | output | 16 | Readback value (combinational) |
| req_valid_i | input | 1 | Write request valid |
| req_addr_i | input | 16 | Word address of the write |
| req_priv_i | input | 1 | Privileged flag for the write |
| grant_o | output | 1 | Write allowed, one cycle after the request |
| viol_o | output | 1 | Write refused, one cycle after the request |
| bad_cfg_o | output | 1 | Unprivileged update attempt, one cycle after it |

## Verification
The bench builds the block with its default parameters. Those give a 16-bit address, 256-word pages and 16-bit registers, which is sixteen registers and 256 pages in all. Random addresses and register indices therefore reach every page and both ends of the index range, including register 0 and register 15. The directed cases cover:
- the edges of one page, on both sides of a page boundary;
- an update and a request to the same register in the same cycle;
- readback sweeps of the whole bank right after reset.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_GRANT = 2'd1,
    DEC_VIOL  = 2'd2
  } dec_e;
endpackage

// File: rtl/wprot_bank.sv
module wprot_bank #(
  parameter int REG_W    = 16,
  parameter int SEL_W    = 4,
  localparam int NUM_REGS = 2 ** SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [SEL_W-1:0] upd_idx_i,
  input  logic [REG_W-1:0] upd_data_i,
  input  logic [SEL_W-1:0] rd_idx_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic [SEL_W-1:0] lk_idx_i,
  output logic [REG_W-1:0] lk_data_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (upd_i && upd_idx_i == SEL_W'(g)) regs_q[g] <= upd_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
  // lookup sees pre-update contents (R9)
  assign lk_data_o = regs_q[lk_idx_i];
endmodule

// File: rtl/wprot_cfg_gate.sv
module wprot_cfg_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic priv_i,
  output logic upd_o,
  output logic bad_o
);
  assign upd_o = we_i & priv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bad_o <= 1'b0;
    else         bad_o <= we_i & ~priv_i;
  end
endmodule

// File: rtl/wprot_decide.sv
module wprot_decide
  import wprot_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int BIT_W = $clog2(REG_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             priv_i,
  input  logic [REG_W-1:0] row_i,
  input  logic [BIT_W-1:0] bit_sel_i,
  output logic             grant_o,
  output logic             viol_o
);
  dec_e dec_d, dec_q;
  logic prot;

  assign prot = row_i[bit_sel_i];

  always_comb begin
    dec_d = DEC_NONE;
    if (valid_i) dec_d = (priv_i || !prot) ? DEC_GRANT : DEC_VIOL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= DEC_NONE;
    else         dec_q <= dec_d;
  end

  assign grant_o = (dec_q == DEC_GRANT);
  assign viol_o  = (dec_q == DEC_VIOL);
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int REG_W  = 16,
  localparam int PG_W  = ADDR_W - PAGE_W,
  localparam int BIT_W = $clog2(REG_W),
  localparam int SEL_W = PG_W - BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic [SEL_W-1:0]  cfg_idx_i,
  input  logic [REG_W-1:0]  cfg_data_i,
  input  logic [SEL_W-1:0]  rd_idx_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_priv_i,
  output logic              grant_o,
  output logic              viol_o,
  output logic              bad_cfg_o
);
  logic             upd;
  logic [REG_W-1:0] row;
  logic [PG_W-1:0]  page;

  assign page = req_addr_i[ADDR_W-1:PAGE_W];

  wprot_cfg_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .priv_i (cfg_priv_i),
    .upd_o  (upd),
    .bad_o  (bad_cfg_o)
  );

  wprot_bank #(.REG_W(REG_W), .SEL_W(SEL_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .upd_idx_i  (cfg_idx_i),
    .upd_data_i (cfg_data_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o),
    .lk_idx_i   (page[PG_W-1:BIT_W]),
    .lk_data_o  (row)
  );

  wprot_decide #(.REG_W(REG_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .priv_i    (req_priv_i),
    .row_i     (row),
    .bit_sel_i (page[BIT_W-1:0]),
    .grant_o   (grant_o),
    .viol_o    (viol_o)
  );
endmodule

// File: rtl/wprot_guard_chk.sv
module wprot_guard_chk #(
  parameter int SEL_W = 4,
  parameter int REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             cfg_priv_i,
  input logic [SEL_W-1:0] cfg_idx_i,
  input logic [REG_W-1:0] cfg_data_i,
  input logic [SEL_W-1:0] rd_idx_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             req_valid_i,
  input logic             req_priv_i,
  input logic             grant_o,
  input logic             viol_o,
  input logic             bad_cfg_o
);
  AST_DEC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && viol_o)); // R4
  AST_NO_IDLE_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !grant_o && !viol_o); // R4
  AST_VALID_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_o || viol_o); // R4
  AST_PRIV_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_priv_i |=> grant_o); // R7
  AST_BAD_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_priv_i |=> bad_cfg_o); // R3
  AST_NO_BAD_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && !cfg_priv_i) |=> !bad_cfg_o); // R3
  AST_CFG_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_priv_i |=> $stable(rd_idx_i) -> $stable(rd_data_o)); // R3
  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_priv_i |=> rd_idx_i == $past(cfg_idx_i) -> rd_data_o == $past(cfg_data_i)); // R2
endmodule

bind wprot_guard wprot_guard_chk #(.SEL_W(SEL_W), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_priv_i  (cfg_priv_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_data_i  (cfg_data_i),
  .rd_idx_i    (rd_idx_i),
  .rd_data_o   (rd_data_o),
  .req_valid_i (req_valid_i),
  .req_priv_i  (req_priv_i),
  .grant_o     (grant_o),
  .viol_o      (viol_o),
  .bad_cfg_o   (bad_cfg_o)
);

// File: tb/tb_wprot_guard.sv
`timescale 1ns/1ps
module tb_wprot_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_priv = 1'b0;
  logic [3:0]  cfg_idx = '0, rd_idx = '0;
  logic [15:0] cfg_data = '0, req_addr = '0;
  logic        req_valid = 1'b0, req_priv = 1'b0;
  logic [15:0] rd_data;
  logic        grant, viol, bad_cfg;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model [16];

  always #2 clk = ~clk;

  wprot_guard dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_priv_i(req_priv),
    .grant_o(grant), .viol_o(viol), .bad_cfg_o(bad_cfg)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit prot_bit(logic [15:0] a);
    return model[a[15:12]][a[11:8]];
  endfunction

  task automatic step(bit cw, bit cp, logic [3:0] ci, logic [15:0] cd,
                      bit rv, logic [15:0] ra, bit rp, logic [3:0] ri, string tag);
    bit eg, ev, eb;
    string dt;
    @(negedge clk);
    cfg_we = cw; cfg_priv = cp; cfg_idx = ci; cfg_data = cd;
    req_valid = rv; req_addr = ra; req_priv = rp; rd_idx = ri;
    eg = rv && (rp || !prot_bit(ra));
    ev = rv && !rp && prot_bit(ra);
    eb = cw && !cp;
    if (tag != "") dt = tag;
    else if (!rv) dt = "R4";
    else if (rp) dt = "R7";
    else if (prot_bit(ra)) dt = "R5";
    else dt = "R6";
    if (cw && cp) model[ci] = cd;
    @(posedge clk); #1;
    chk({dt, " grant"}, 16'(grant), 16'(eg));
    chk({dt, " viol"}, 16'(viol), 16'(ev));
    chk("R3 bad_cfg", 16'(bad_cfg), 16'(eb));
    chk((cw && !cp) ? "R3 readback" : "R2 readback", rd_data, model[ri]);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared bank, everything writable
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); rd_idx = 4'(i); #1;
      chk("R1 reset readback", rd_data, 16'h0000);
    end
    step(0, 0, 0, 0, 1, 16'hFFFF, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 16'h0000, 0, 15, "R1");

    // R8: page 0x37 = reg 3 bit 7
    step(1, 1, 3, 16'h0080, 0, 0, 0, 3, "R2");
    step(0, 0, 0, 0, 1, 16'h3700, 0, 3, "R8");
    step(0, 0, 0, 0, 1, 16'h37FF, 0, 3, "R8");
    step(0, 0, 0, 0, 1, 16'h3800, 0, 3, "R8");
    step(0, 0, 0, 0, 1, 16'h36FF, 0, 3, "R8");
    step(0, 0, 0, 0, 1, 16'h3742, 1, 3, "R7");
    step(0, 0, 0, 0, 0, 16'h3742, 0, 3, "R4");
    // R3: unprivileged clear of reg 3 ignored
    step(1, 0, 3, 16'h0000, 0, 0, 0, 3, "R3");
    step(0, 0, 0, 0, 1, 16'h3701, 0, 3, "R3");
    // R9: update and request to reg 3 in the same cycle
    step(1, 1, 3, 16'h0000, 1, 16'h3710, 0, 3, "R9");
    step(0, 0, 0, 0, 1, 16'h3710, 0, 3, "R9");
    step(1, 1, 15, 16'h8000, 1, 16'hFF00, 0, 15, "R9");
    step(0, 0, 0, 0, 1, 16'hFF00, 0, 15, "R5");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit cw, cp, rv, rp;
      logic [15:0] cd, ra;
      cw = ($urandom % 4) == 0;
      cp = ($urandom % 3) != 0;
      cd = 16'($urandom);
      rv = ($urandom % 4) != 0;
      rp = ($urandom % 5) == 0;
      ra = 16'($urandom);
      step(cw, cp, 4'($urandom), cd, rv, ra, rp, 4'($urandom), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule